// File: doc/BRIEF.md
# Four-Bit ECC Correction Sequencer

This block runs the read-side correction flow for one 512-byte sector protected by a four-symbol-correcting code. The block does not do the polynomial arithmetic. That work belongs to a separate syndrome and error-locator engine. The sequencer reaches the engine through a small register-style request port and uses it in a fixed order:

1. It feeds the engine the code bytes that were stored with the sector.
2. It asks whether any errors were seen.
3. If errors were seen, it starts the location step and waits until the engine has really begun.
4. It reads back each error location and the pattern to apply.

Each error is repaired in place with a read-modify-write on a byte-wide sector buffer.

A client latches ten stored code bytes and pulses `start`. When the sequence ends, `done` pulses for one cycle. At that point `fix_count` gives the number of bytes repaired and `uncorrectable` reports a sector with too many errors to repair. Both outputs hold their values until the next accepted start.

Top module: `ecc4_fix_seq`

## Requirements
- R1: When all ten code bytes on `code_in` are 0xFF, the sector counts as erased. The block then finishes with `fix_count` 0 and `uncorrectable` 0, and it makes no engine request and no buffer write. A single byte that differs from 0xFF is enough to run the full flow.
- R2: `code_in` holds byte i at bits [8i+7:8i]. The eight 10-bit check values are consecutive 10-bit slices of this vector, taken from the least significant bit upward: value k is `code_in[10k+9:10k]`. Bytes 0–4 therefore give values 0–3, and bytes 5–9 give values 4–7.
- R3: The eight values are written to select 0 (load) as writes with the value in `eng_wdata[9:0]`. They are sent in descending index order, value 7 first and value 0 last. Exactly eight load writes occur.
- R4: Selects 1 to 4 are read as the four syndrome words. Each word is masked with 0x03FF03FF before use. If the OR of the four masked words is zero, the block finishes with no corrections and never writes select 6.
- R5: When errors exist, a read of select 7 (first error-address pair) comes before the start write to select 6.
- R6: After the start write, the status word at select 5 has its state field in bits [11:8]. Reads with a state below 4 do not end the wait phase. The wait phase ends either on a read with state 4 or higher, or on the first status read completed after GUARD_CYCLES cycles in the wait phase.
- R7: Polling then continues until the state is 0 to 3. State 0 ends the flow with zero corrections. State 1 sets `uncorrectable` with zero corrections. States 2 and 3 give an error count of 1 plus status bits [17:16].
- R8: The address of error j comes from select 7 for j < 2 and from select 8 otherwise. Its value comes from select 9 or select 10 on the same split. Odd j uses bits [25:16] of the address word and bits [23:16] of the value word. Even j uses bits [9:0] and bits [7:0].
- R9: A reported address a maps to byte offset 519 − a. Only offsets 0 to 511 are repaired, by XOR of the buffer byte with the value, and only those are counted in `fix_count`.
- R10: An engine request holds `eng_req`, `eng_sel`, `eng_we` and `eng_wdata` steady until the cycle in which `eng_ack` is high. Read data is taken in that cycle.
- R11: `done` is high for exactly one cycle per accepted start. `fix_count` and `uncorrectable` stay valid after it until the next accepted start.
- R12: `start` is ignored while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence with the bytes on `code_in` |
| code_in | input | 80 | Ten stored code bytes, byte i at bits [8i+7:8i] |
| done | output | 1 | One-cycle end-of-sequence pulse |
| uncorrectable | output | 1 | The engine reported too many errors |
| fix_count | output | 3 | Number of bytes repaired |
| eng_req | output | 1 | Engine request valid |
| eng_we | output | 1 | Request is a write |
| eng_sel | output | 4 | Engine register select |
| eng_wdata | output | 32 | Write data |
| eng_ack | input | 1 | Request accepted; read data valid |
| eng_rdata | input | 32 | Read data |
| buf_re | output | 1 | Sector buffer read enable (data one cycle later) |
| buf_we | output | 1 | Sector buffer write enable |
| buf_addr | output | 9 | Sector buffer byte offset |
| buf_wdata | output | 8 | Repaired byte |
| buf_rdata | input | 8 | Byte read from the sector buffer |

## Verification
The hardest situation to reach is an engine that returns the misleading "complete" state 3 right after the start write, before its real result exists. The behavioural engine in the bench can be told to answer a chosen number of status reads with state 3 and a wrong error count, then a busy state, then the real result. A correct sequencer must wait through the early state 3. A second setting keeps the early state 3 forever, which makes the guard timeout the only way forward. Error addresses cover the edges of the 519 − a window (7, 8, 519, 520, 0, 1023). The engine also sets the unused bits of every read word, so wrong masking or wrong half selection changes the repaired bytes.

// File: rtl/ecc4_pkg.sv
// Shared constants and encodings for the four-bit ECC correction sequencer.
// Assumes a 32-bit engine register port and 10-bit check values.
package ecc4_pkg;
    localparam int VAL_W    = 10;
    localparam int N_VALS   = 8;
    localparam int CODE_W   = N_VALS * VAL_W;
    localparam int WORD_W   = 32;
    localparam logic [WORD_W-1:0] SYN_MASK = 32'h03FF_03FF;

    // Engine register selects
    typedef enum logic [3:0] {
        SEL_LOAD    = 4'd0,
        SEL_SYN0    = 4'd1,
        SEL_STAT    = 4'd5,
        SEL_GO      = 4'd6,
        SEL_ADDR_LO = 4'd7,
        SEL_ADDR_HI = 4'd8,
        SEL_VAL_LO  = 4'd9,
        SEL_VAL_HI  = 4'd10
    } eng_sel_e;

    // Sequencer phases
    typedef enum logic [3:0] {
        PH_IDLE, PH_CHECK, PH_LOAD, PH_SYN, PH_CLEAR, PH_GO,
        PH_GUARD, PH_POLL, PH_GET_ADDR, PH_GET_VAL, PH_BUF_RD,
        PH_BUF_WR, PH_DONE
    } seq_phase_e;
endpackage

// File: rtl/ecc4_code_unpack.sv
// Splits the stored code vector into N_VALS check values of VAL_W bits each,
// low bits first, and flags an all-ones (erased) code.
// Assumes the code vector holds its bytes little-endian.
module ecc4_code_unpack #(
    parameter int N_VALS = 8,
    parameter int VAL_W  = 10
) (
    input  logic [N_VALS*VAL_W-1:0]      code,
    output logic [N_VALS-1:0][VAL_W-1:0] vals,
    output logic                         erased
);
    // One slice per check value
    for (genvar k = 0; k < N_VALS; k++) begin : g_slice
        assign vals[k] = code[k*VAL_W +: VAL_W];
    end

    // Erased page: every stored bit is one
    assign erased = &code;
endmodule

// File: rtl/ecc4_loc_map.sv
// Turns an engine-reported error location into a sector byte offset
// (BIAS minus location) and flags whether it lies inside the sector.
// Assumes BIAS fits in AW bits.
module ecc4_loc_map #(
    parameter int AW     = 10,
    parameter int BIAS   = 519,
    parameter int SECTOR = 512,
    parameter int OW     = 9
) (
    input  logic [AW-1:0] loc,
    output logic [OW-1:0] offset,
    output logic          in_range
);
    localparam int DW = AW + 2;

    logic [DW-1:0] diff;

    // Signed difference; a negative result sets the top bit
    assign diff     = DW'(BIAS) - {2'b00, loc};
    assign in_range = ~diff[DW-1] && (diff < DW'(SECTOR));
    assign offset   = diff[OW-1:0];
endmodule

// File: rtl/ecc4_guard_timer.sv
// Counts cycles spent in the start-up guard phase and saturates at LIMIT.
// Assumes clear is held whenever the guard phase is not active.
module ecc4_guard_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Saturating cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (en && cnt != CW'(LIMIT))
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == CW'(LIMIT));

    // Once expired, the timer stays expired while the guard phase lasts
    assert_timer_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clear && expired) |=> (expired || clear));
endmodule

// File: rtl/ecc4_fix_seq.sv
// Four-bit ECC correction sequencer. It loads the stored check values into
// an external syndrome/locator engine, tests the syndrome, starts location
// behind a guard against an early false "complete", then reads each error
// and repairs the sector buffer by read-modify-write.
// Assumes the engine acks each request in a later cycle and the buffer
// returns read data one cycle after buf_re.
module ecc4_fix_seq
    import ecc4_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int ADDR_BIAS    = 519,
    parameter int GUARD_CYCLES = 100,
    parameter int STATE_LIVE   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CODE_W-1:0]    code_in,
    output logic                 done,
    output logic                 uncorrectable,
    output logic [2:0]           fix_count,
    output logic                 eng_req,
    output logic                 eng_we,
    output logic [3:0]           eng_sel,
    output logic [WORD_W-1:0]    eng_wdata,
    input  logic                 eng_ack,
    input  logic [WORD_W-1:0]    eng_rdata,
    output logic                 buf_re,
    output logic                 buf_we,
    output logic [$clog2(SECTOR_BYTES)-1:0] buf_addr,
    output logic [7:0]           buf_wdata,
    input  logic [7:0]           buf_rdata
);
    localparam int BAW = $clog2(SECTOR_BYTES);

    seq_phase_e                   ph;
    logic [CODE_W-1:0]            code_q;
    logic [N_VALS-1:0][VAL_W-1:0] vals;
    logic                         erased;
    logic [2:0]                   idx;
    logic [2:0]                   err_total;
    logic [WORD_W-1:0]            syn_acc;
    logic [WORD_W-1:0]            syn_next;
    logic [VAL_W-1:0]             cur_loc;
    logic [7:0]                   cur_val;
    logic [BAW-1:0]               cur_off;
    logic                         loc_ok;
    logic [2:0]                   fixes;
    logic                         uncorr;
    logic                         guard_expired;
    logic [3:0]                   stat_state;
    logic [1:0]                   stat_cnt;
    logic                         last_err;

    ecc4_code_unpack #(.N_VALS(N_VALS), .VAL_W(VAL_W)) i_unpack (
        .code   (code_q),
        .vals   (vals),
        .erased (erased)
    );

    ecc4_loc_map #(.AW(VAL_W), .BIAS(ADDR_BIAS), .SECTOR(SECTOR_BYTES), .OW(BAW)) i_map (
        .loc      (cur_loc),
        .offset   (cur_off),
        .in_range (loc_ok)
    );

    ecc4_guard_timer #(.LIMIT(GUARD_CYCLES)) i_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ph != PH_GUARD),
        .en      (ph == PH_GUARD),
        .expired (guard_expired)
    );

    // Decode fields of the returned words
    assign stat_state = eng_rdata[11:8];
    assign stat_cnt   = eng_rdata[17:16];
    assign syn_next   = syn_acc | (eng_rdata & SYN_MASK);
    assign last_err   = (idx == err_total - 3'd1);

    // Main phase sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= PH_IDLE;
            code_q    <= '0;
            idx       <= '0;
            err_total <= '0;
            syn_acc   <= '0;
            cur_loc   <= '0;
            cur_val   <= '0;
            fixes     <= '0;
            uncorr    <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: if (start) begin
                    code_q <= code_in;
                    fixes  <= '0;
                    uncorr <= 1'b0;
                    ph     <= PH_CHECK;
                end
                PH_CHECK: begin
                    idx <= 3'(N_VALS - 1);
                    ph  <= erased ? PH_DONE : PH_LOAD;
                end
                PH_LOAD: if (eng_ack) begin
                    if (idx == 3'd0) begin
                        syn_acc <= '0;
                        ph      <= PH_SYN;
                    end else begin
                        idx <= idx - 3'd1;
                    end
                end
                PH_SYN: if (eng_ack) begin
                    syn_acc <= syn_next;
                    if (idx == 3'd3) begin
                        idx <= '0;
                        ph  <= (syn_next == '0) ? PH_DONE : PH_CLEAR;
                    end else begin
                        idx <= idx + 3'd1;
                    end
                end
                PH_CLEAR: if (eng_ack) ph <= PH_GO;
                PH_GO:    if (eng_ack) ph <= PH_GUARD;
                PH_GUARD: if (eng_ack && (stat_state >= 4'(STATE_LIVE) || guard_expired))
                    ph <= PH_POLL;
                PH_POLL: if (eng_ack) begin
                    case (stat_state)
                        4'd0: ph <= PH_DONE;
                        4'd1: begin
                            uncorr <= 1'b1;
                            ph     <= PH_DONE;
                        end
                        4'd2, 4'd3: begin
                            err_total <= {1'b0, stat_cnt} + 3'd1;
                            idx       <= '0;
                            ph        <= PH_GET_ADDR;
                        end
                        default: ph <= PH_POLL;
                    endcase
                end
                PH_GET_ADDR: if (eng_ack) begin
                    cur_loc <= idx[0] ? eng_rdata[25:16] : eng_rdata[9:0];
                    ph      <= PH_GET_VAL;
                end
                PH_GET_VAL: if (eng_ack) begin
                    cur_val <= idx[0] ? eng_rdata[23:16] : eng_rdata[7:0];
                    if (loc_ok) begin
                        ph <= PH_BUF_RD;
                    end else begin
                        idx <= idx + 3'd1;
                        ph  <= last_err ? PH_DONE : PH_GET_ADDR;
                    end
                end
                PH_BUF_RD: ph <= PH_BUF_WR;
                PH_BUF_WR: begin
                    fixes <= fixes + 3'd1;
                    idx   <= idx + 3'd1;
                    ph    <= last_err ? PH_DONE : PH_GET_ADDR;
                end
                PH_DONE: ph <= PH_IDLE;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Engine request decode per phase
    always_comb begin
        eng_req   = 1'b1;
        eng_we    = 1'b0;
        eng_sel   = 4'(SEL_STAT);
        eng_wdata = '0;
        case (ph)
            PH_LOAD: begin
                eng_we    = 1'b1;
                eng_sel   = 4'(SEL_LOAD);
                eng_wdata = WORD_W'(vals[idx]);
            end
            PH_SYN:      eng_sel = 4'(SEL_SYN0) + {2'b00, idx[1:0]};
            PH_CLEAR:    eng_sel = 4'(SEL_ADDR_LO);
            PH_GO: begin
                eng_we  = 1'b1;
                eng_sel = 4'(SEL_GO);
            end
            PH_GUARD, PH_POLL: eng_sel = 4'(SEL_STAT);
            PH_GET_ADDR: eng_sel = idx[1] ? 4'(SEL_ADDR_HI) : 4'(SEL_ADDR_LO);
            PH_GET_VAL:  eng_sel = idx[1] ? 4'(SEL_VAL_HI) : 4'(SEL_VAL_LO);
            default:     eng_req = 1'b0;
        endcase
    end

    // Sector buffer access and result outputs
    assign buf_re        = (ph == PH_BUF_RD);
    assign buf_we        = (ph == PH_BUF_WR);
    assign buf_addr      = cur_off;
    assign buf_wdata     = buf_rdata ^ cur_val;
    assign done          = (ph == PH_DONE);
    assign fix_count     = fixes;
    assign uncorrectable = uncorr;

    // A pending request keeps its command fields until accepted
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=> (eng_req && $stable(eng_sel) && $stable(eng_we) && $stable(eng_wdata)));

    // Loads are always writes
    assert_load_is_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_sel == 4'(SEL_LOAD)) |-> eng_we);

    // Done is a single-cycle pulse
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A buffer write repairs the byte read in the cycle before
    assert_rmw_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> ($past(buf_re) && buf_addr == $past(buf_addr)));

    // An uncorrectable result never carries repairs
    assert_uncorr_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && uncorrectable) |-> (fix_count == 3'd0));

    // At most four repairs per sector
    assert_fix_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fix_count <= 3'd4));
endmodule

// File: tb/test_ecc4_fix_seq.sv
// Self-checking bench: behavioural engine stub plus sector memory; sweeps
// error counts, boundary addresses, guard behaviour and control corners.
module test_ecc4_fix_seq;
    localparam int CLK_PERIOD = 10;
    localparam int GUARD      = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [79:0] code_in = '0;
    logic        done, uncorrectable, eng_req, eng_we, eng_ack, buf_re, buf_we;
    logic [2:0]  fix_count;
    logic [3:0]  eng_sel;
    logic [31:0] eng_wdata, eng_rdata;
    logic [8:0]  buf_addr;
    logic [7:0]  buf_wdata, buf_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc4_fix_seq #(.GUARD_CYCLES(GUARD)) i_ecc4_fix_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .code_in(code_in),
        .done(done), .uncorrectable(uncorrectable), .fix_count(fix_count),
        .eng_req(eng_req), .eng_we(eng_we), .eng_sel(eng_sel), .eng_wdata(eng_wdata),
        .eng_ack(eng_ack), .eng_rdata(eng_rdata),
        .buf_re(buf_re), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
    );

    int checks = 0;
    int fails  = 0;

    // Scenario, set by the test sequence
    logic [31:0] syn [4];
    int          early_n, early_cnt, busy_n, fstate, fcnt, case_id;
    logic [9:0]  locs [4];
    logic [7:0]  pats [4];
    logic        stub_clr = 1'b0;

    // Observations, written by the stub
    logic [9:0]  load_log [16];
    int          load_n, txn_n, stat_after, done_n, wr_n;
    bit          started, clr_seen, start_ok;
    logic [7:0]  mem [512];
    logic [7:0]  exp_mem [512];

    function automatic logic [7:0] init_byte(input int i, input int c);
        return 8'(i * 29 + c * 7 + 3);
    endfunction

    // Engine stub and sector memory
    always @(posedge clk) begin
        if (stub_clr) begin
            eng_ack = 1'b0;
            load_n = 0; txn_n = 0; stat_after = 0; done_n = 0; wr_n = 0;
            started = 0; clr_seen = 0; start_ok = 0;
            for (int i = 0; i < 512; i++) mem[i] = init_byte(i, case_id);
        end else begin
            if (done) done_n++;
            if (eng_req && !eng_ack) begin
                txn_n++;
                case (eng_sel)
                    4'd0: begin
                        if (load_n < 16) load_log[load_n] = eng_wdata[9:0];
                        load_n++;
                    end
                    4'd1, 4'd2, 4'd3, 4'd4:
                        eng_rdata <= syn[eng_sel - 4'd1] | 32'hFC00_FC00;
                    4'd5: begin
                        if (!started) eng_rdata <= 32'h0000_0300;
                        else if (stat_after < early_n)
                            eng_rdata <= {14'h2AAA, 2'(early_cnt), 4'h0, 4'd3, 8'hA5};
                        else if (stat_after < early_n + busy_n)
                            eng_rdata <= {14'h1555, 2'b11, 4'h0, 4'd9, 8'h5A};
                        else
                            eng_rdata <= {14'h2AAA, 2'(fcnt), 4'h0, 4'(fstate), 8'hC3};
                        if (started) stat_after++;
                    end
                    4'd6: begin
                        started  = 1;
                        start_ok = clr_seen;
                    end
                    4'd7: begin
                        if (!started) clr_seen = 1;
                        eng_rdata <= {6'h2A, locs[1], 6'h15, locs[0]};
                    end
                    4'd8:  eng_rdata <= {6'h2A, locs[3], 6'h15, locs[2]};
                    4'd9:  eng_rdata <= {8'hC3, pats[1], 8'h5A, pats[0]};
                    4'd10: eng_rdata <= {8'h3C, pats[3], 8'hA5, pats[2]};
                    default: eng_rdata <= 32'hDEAD_BEEF;
                endcase
            end
            eng_ack <= eng_req && !eng_ack;
        end
        if (buf_re) buf_rdata <= mem[buf_addr];
        if (buf_we) begin
            mem[buf_addr] = buf_wdata;
            wr_n++;
        end
    end

    // Global watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int loc_table(input int k);
        case (k)
            0: return 7;   1: return 8;   2: return 9;
            3: return 300; 4: return 518; 5: return 519;
            6: return 520; 7: return 1023; default: return 0;
        endcase
    endfunction

    function automatic logic [79:0] make_code(input int c);
        logic [79:0] v;
        for (int i = 0; i < 10; i++) v[8*i +: 8] = 8'(c * 37 + i * 11 + 1);
        return v;
    endfunction

    // Run one sequence and check every observable result
    task automatic run_case(input logic [79:0] code, input bit busy_start);
        bit erased_exp, zero_exp, got_done;
        int eff_state, eff_cnt, exp_fix, exp_unc, bad;
        logic [31:0] acc;

        @(negedge clk); stub_clr = 1'b1;
        @(negedge clk); stub_clr = 1'b0;
        for (int i = 0; i < 512; i++) exp_mem[i] = init_byte(i, case_id);

        erased_exp = (code == {80{1'b1}});
        acc = '0;
        for (int w = 0; w < 4; w++) acc = acc | (syn[w] & 32'h03FF_03FF);
        zero_exp = (acc == 0);
        eff_state = (early_n >= 1000) ? 3 : fstate;
        eff_cnt   = (early_n >= 1000) ? early_cnt : fcnt;
        exp_fix = 0; exp_unc = 0;
        if (!erased_exp && !zero_exp) begin
            if (eff_state == 1) exp_unc = 1;
            else if (eff_state >= 2) begin
                for (int j = 0; j <= eff_cnt; j++) begin
                    int off;
                    off = 519 - int'(locs[j]);
                    if (off >= 0 && off < 512) begin
                        exp_mem[off] = exp_mem[off] ^ pats[j];
                        exp_fix++;
                    end
                end
            end
        end

        code_in = code;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        code_in = {80{1'b1}};
        got_done = 0;
        for (int k = 0; k < 6000; k++) begin
            if (busy_start && k == 6) start = 1'b1;
            if (busy_start && k == 7) start = 1'b0;
            if (done) begin got_done = 1; break; end
            @(negedge clk);
        end
        check(got_done, "R11", "done seen", int'(got_done), 1);
        check(fix_count == 3'(exp_fix), "R9", "fix_count", int'(fix_count), exp_fix);
        check(uncorrectable == 1'(exp_unc), "R7", "uncorrectable", int'(uncorrectable), exp_unc);
        if (erased_exp) begin
            check(txn_n == 0, "R1", "engine requests on erased page", txn_n, 0);
        end else begin
            check(load_n == 8, "R3 R10", "load write count", load_n, 8);
            bad = 0;
            for (int j = 0; j < 8; j++)
                if (load_log[j] != code[10*(7-j) +: 10]) bad++;
            check(bad == 0, "R2 R3", "load values out of order or wrong", bad, 0);
            if (zero_exp) check(!started, "R4", "start issued on clean syndrome", int'(started), 0);
            else          check(start_ok, "R5", "dummy read before start", int'(start_ok), 1);
        end
        bad = 0;
        for (int i = 0; i < 512; i++) if (mem[i] != exp_mem[i]) bad++;
        check(bad == 0, "R9", "sector bytes mismatched", bad, 0);
        check(wr_n == exp_fix, "R9", "buffer writes", wr_n, exp_fix);
        repeat (3) @(negedge clk);
        check(done_n == 1, "R11 R12", "done pulses", done_n, 1);
        check(fix_count == 3'(exp_fix), "R11", "fix_count held", int'(fix_count), exp_fix);
    endtask

    task automatic default_scenario();
        for (int w = 0; w < 4; w++) syn[w] = 32'h0;
        syn[2] = 32'h0000_0040;
        early_n = 0; early_cnt = 0; busy_n = 2; fstate = 2; fcnt = 0;
        for (int j = 0; j < 4; j++) begin
            locs[j] = 10'(100 + j * 50);
            pats[j] = 8'(8'h21 << j);
        end
    endtask

    initial begin
        case_id = 0;
        default_scenario();
        repeat (3) @(negedge clk);
        check(done == 0 && eng_req == 0 && buf_we == 0 && buf_re == 0, "R11", "reset idle outputs",
              int'({done, eng_req, buf_we, buf_re}), 0);
        check(fix_count == 0 && uncorrectable == 0, "R11", "reset results",
              int'({uncorrectable, fix_count}), 0);
        @(negedge clk); rst_n = 1'b1;

        // R1 erased page
        case_id = 1; run_case({80{1'b1}}, 0);
        // R1 boundary: one byte off erased, clean syndrome (R4)
        case_id = 2; for (int w = 0; w < 4; w++) syn[w] = 32'hFC00_FC00;
        run_case({{72{1'b1}}, 8'hFE}, 0);
        // R4 syndrome set only in masked-out bits, then each word alone
        default_scenario();
        for (int w = 0; w < 4; w++) begin
            case_id = 3 + w;
            for (int x = 0; x < 4; x++) syn[x] = 32'h0;
            syn[w] = 32'h0200_0000 >> (w * 4);
            run_case(make_code(case_id), 0);
        end
        // R7 state 0 and state 1
        default_scenario(); fstate = 0; case_id = 8; run_case(make_code(8), 0);
        default_scenario(); fstate = 1; fcnt = 3; case_id = 9; run_case(make_code(9), 0);
        // R8 R9 sweep over error counts and boundary locations
        for (int s = 0; s < 6; s++) begin
            for (int n = 1; n <= 4; n++) begin
                default_scenario();
                for (int x = 0; x < 4; x++) syn[x] = 32'h0;
                syn[s % 4] = 32'h1 << (s * 3);
                fstate = 2 + ((s + n) % 2);
                fcnt   = n - 1;
                for (int j = 0; j < 4; j++) begin
                    locs[j] = 10'(loc_table((s * 3 + j * 2 + n) % 9));
                    pats[j] = 8'((8'h11 * (j + 1)) ^ (s * 5) ^ n);
                end
                case_id = 10 + s * 4 + n;
                run_case(make_code(case_id), 0);
            end
        end
        // R6 misleading early state 3 with a wrong count, then busy, then result
        default_scenario(); early_n = 5; early_cnt = 0; busy_n = 3; fstate = 2; fcnt = 3;
        locs[0] = 10'd9; locs[1] = 10'd200; locs[2] = 10'd519; locs[3] = 10'd8;
        case_id = 40; run_case(make_code(40), 0);
        // R6 timeout: state stays 3 forever, guard timer must release
        default_scenario(); early_n = 1000; early_cnt = 1; fstate = 0;
        case_id = 41; run_case(make_code(41), 0);
        // R12 start pulse during a sequence is ignored
        default_scenario(); fcnt = 2; case_id = 42; run_case(make_code(42), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule